// File: doc/BRIEF.md
# Byte-Memory DMA Engine with Boot Load

This block moves data between an 8-bit wide external byte memory and on-chip word memory without processor involvement. Going inward, it gathers consecutive bytes into one word (three bytes for a 24-bit program word, two for a 16-bit data word) and writes the finished word to internal memory in a single cycle. Going outward, it fetches a word from internal memory and writes its bytes out one at a time. Software sets up a direction, a page, the two start addresses, the word type, a wait-state count and a context-reset bit through a small register write port. A nonzero write to the word count starts the engine, which runs until the count reaches zero.

Every byte access holds the bus for the programmed number of wait states. Processor accesses to external memory come first: the engine starts no new byte access while the processor asks for the bus. When the context-reset bit is set, the processor is held for the whole transfer and gets a one-cycle restart pulse at the end, so it clears its context and begins execution at address 0.

When the boot strap is high during reset, the registers come up ready to load a block of program words from byte address 0 with the processor held. The load starts by itself once reset is released, so the first code can be fetched without any software setup.

Top module: `bytedma_engine`

## Requirements
- R1: A write of a nonzero value to the count register (select 4) starts a transfer and raises `busy`. A write of zero leaves the engine idle with `busy` low and makes no byte access. `busy` stays high until the count has reached zero.
- R2: Each byte access drives `bm_req` high for exactly wait+1 consecutive cycles, where wait is the value in the wait register (select 3). `bm_addr` equals {page, external address} and stays stable for the whole access.
- R3: The word type is control bit 1. Type 0 builds a 24-bit word from 3 consecutive bytes and type 1 builds a 16-bit word from 2 bytes, zero-extended to 24 bits. The first byte is the most significant. The external address (select 2) increases by one after every byte.
- R4: With direction 0 (control bit 0), each finished word is written to internal memory with `im_we` high for a single cycle at the internal address (select 1). The internal address then increments and the count decrements. Exactly `count` words are written, and no location past the last one changes.
- R5: With direction 1, the engine reads each word through `im_re`, with the data valid on `im_rdata` one cycle later. It writes the word's bytes to byte memory most significant first, with `bm_we` high, and never asserts `im_we`.
- R6: No byte access begins in the cycle after `cpu_ext_req` was high. Processor external accesses take priority.
- R7: With context-reset (control bit 2) at 0, `proc_hold` stays low and `ctx_restart` never pulses. With it at 1, `proc_hold` is high for every busy cycle, and `ctx_restart` pulses for one cycle in the first cycle that `busy` is low.
- R8: A reset with `boot_en` high sets direction, type, page and both addresses to 0, the count to BOOT_WORDS (32), the wait count to BOOT_WAIT (3) and context-reset to 1. A 32-word program load from byte addresses 0 to 95 therefore starts on its own, with the processor held.
- R9: A reset with `boot_en` low leaves the count at 0, so `busy` and `proc_hold` are low.
- R10: While `busy` is high, writes to any register are ignored. The transfer in progress keeps its count and external address.
- Control register (select 0) layout: bit 0 direction, bit 1 type, bit 2 context-reset, bits PAGE_W+2:3 page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_en | input | 1 | Boot strap, sampled during reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 internal address, 2 external address, 3 wait, 4 count |
| cfg_wdata | input | CFG_W | Register write data |
| busy | output | 1 | Transfer in progress |
| bm_req | output | 1 | Byte-memory access active |
| bm_we | output | 1 | Byte-memory write (direction 1) |
| bm_addr | output | PAGE_W+EA_W | Byte address {page, external address} |
| bm_wdata | output | 8 | Byte to write |
| bm_rdata | input | 8 | Byte read, taken in the last cycle of an access |
| cpu_ext_req | input | 1 | Processor wants the external bus |
| im_we | output | 1 | Internal memory word write |
| im_re | output | 1 | Internal memory word read |
| im_dm | output | 1 | Word type: 0 program 24-bit, 1 data 16-bit |
| im_addr | output | IA_W | Internal word address |
| im_wdata | output | 24 | Word to write |
| im_rdata | input | 24 | Word read, one cycle after `im_re` |
| proc_hold | output | 1 | Hold the processor |
| ctx_restart | output | 1 | One-cycle pulse: clear context, restart at 0 |

## Verification
The bench sweeps direction, word type, three wait counts, single- and multi-word counts and both context-reset settings. It compares every internal word or external byte against values computed from the start addresses. A packer with the wrong byte order or byte count fails these comparisons. Each bus access is timed, so an off-by-one in the wait counter shows up as a wrong access length. The bench checks the location just past each block, which catches an extra transfer or a count that runs past zero. It also toggles the processor bus request during a transfer and rewrites the count and address mid-run. Engines that ignore priority, or that let a busy write restart or redirect the transfer, are caught there. A boot reset then has to load 32 words unaided and end with exactly one restart pulse.

// File: rtl/bytedma_pkg.sv
package bytedma_pkg;
  localparam int WORD_W = 24;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_IADDR = 3'd1,
    SEL_EADDR = 3'd2,
    SEL_WAIT  = 3'd3,
    SEL_COUNT = 3'd4
  } cfg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LOAD, ST_ARB, ST_ACC, ST_XFER
  } seq_state_e;

  typedef struct packed {
    logic ctx;
    logic wtype;
    logic dir;
  } mode_t;
endpackage

// File: rtl/bytedma_regs.sv
module bytedma_regs
  import bytedma_pkg::*;
#(
  parameter int PAGE_W     = 8,
  parameter int IA_W       = 14,
  parameter int EA_W       = 14,
  parameter int WS_W       = 3,
  parameter int CNT_W      = 14,
  parameter int CFG_W      = 16,
  parameter int BOOT_WORDS = 32,
  parameter int BOOT_WAIT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_en,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              byte_step,
  input  logic              word_step,
  output mode_t             mode,
  output logic [PAGE_W-1:0] page,
  output logic [IA_W-1:0]   iaddr,
  output logic [EA_W-1:0]   eaddr,
  output logic [WS_W-1:0]   wait_n,
  output logic              busy,
  output logic              last_word
);
  mode_t             mode_d;
  logic [PAGE_W-1:0] page_d;
  logic [IA_W-1:0]   iaddr_d;
  logic [EA_W-1:0]   eaddr_d;
  logic [WS_W-1:0]   wait_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic              wr_ok;

  assign busy      = |count_q;
  assign last_word = (count_q == CNT_W'(1));
  assign wr_ok     = cfg_we && !busy;

  always_comb begin
    mode_d  = mode;
    page_d  = page;
    iaddr_d = iaddr;
    eaddr_d = eaddr;
    wait_d  = wait_n;
    count_d = count_q;
    if (wr_ok) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_CTRL: begin
          mode_d.dir   = cfg_wdata[0];
          mode_d.wtype = cfg_wdata[1];
          mode_d.ctx   = cfg_wdata[2];
          page_d       = cfg_wdata[PAGE_W+2:3];
        end
        SEL_IADDR: iaddr_d = cfg_wdata[IA_W-1:0];
        SEL_EADDR: eaddr_d = cfg_wdata[EA_W-1:0];
        SEL_WAIT:  wait_d  = cfg_wdata[WS_W-1:0];
        SEL_COUNT: count_d = cfg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
    if (byte_step) eaddr_d = eaddr + EA_W'(1);
    if (word_step) begin
      iaddr_d = iaddr + IA_W'(1);
      count_d = count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode.dir   <= 1'b0;
      mode.wtype <= 1'b0;
      mode.ctx   <= boot_en;
      page       <= '0;
      iaddr      <= '0;
      eaddr      <= '0;
      wait_n     <= boot_en ? WS_W'(BOOT_WAIT) : '0;
      count_q    <= boot_en ? CNT_W'(BOOT_WORDS) : '0;
    end else begin
      mode    <= mode_d;
      page    <= page_d;
      iaddr   <= iaddr_d;
      eaddr   <= eaddr_d;
      wait_n  <= wait_d;
      count_q <= count_d;
    end
  end
endmodule

// File: rtl/bytedma_seq.sv
module bytedma_seq
  import bytedma_pkg::*;
#(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic            last_word,
  input  mode_t           mode,
  input  logic [WS_W-1:0] wait_n,
  input  logic            cpu_ext_req,
  output logic            bm_req,
  output logic            im_we,
  output logic            im_re,
  output logic            cap_byte,
  output logic            load_word,
  output logic            byte_step,
  output logic            word_step
);
  seq_state_e      state_q, state_d;
  logic [WS_W-1:0] wcnt_q, wcnt_d;
  logic [1:0]      bidx_q, bidx_d;
  logic [1:0]      last_idx;

  assign last_idx = mode.wtype ? 2'd1 : 2'd2;

  always_comb begin
    state_d   = state_q;
    wcnt_d    = wcnt_q;
    bidx_d    = bidx_q;
    bm_req    = 1'b0;
    im_we     = 1'b0;
    im_re     = 1'b0;
    cap_byte  = 1'b0;
    load_word = 1'b0;
    byte_step = 1'b0;
    word_step = 1'b0;
    case (state_q)
      ST_IDLE: begin
        bidx_d = '0;
        if (busy) state_d = mode.dir ? ST_FETCH : ST_ARB;
      end
      ST_FETCH: begin
        im_re   = 1'b1;
        state_d = ST_LOAD;
      end
      ST_LOAD: begin
        load_word = 1'b1;
        state_d   = ST_ARB;
      end
      ST_ARB: begin
        if (!cpu_ext_req) begin
          wcnt_d  = '0;
          state_d = ST_ACC;
        end
      end
      ST_ACC: begin
        bm_req = 1'b1;
        if (wcnt_q == wait_n) begin
          byte_step = 1'b1;
          cap_byte  = !mode.dir;
          if (bidx_q == last_idx) begin
            bidx_d  = '0;
            state_d = ST_XFER;
          end else begin
            bidx_d  = bidx_q + 2'd1;
            state_d = ST_ARB;
          end
        end else begin
          wcnt_d = wcnt_q + WS_W'(1);
        end
      end
      ST_XFER: begin
        im_we     = !mode.dir;
        word_step = 1'b1;
        if (last_word)     state_d = ST_IDLE;
        else if (mode.dir) state_d = ST_FETCH;
        else               state_d = ST_ARB;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      bidx_q  <= '0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      bidx_q  <= bidx_d;
    end
  end
endmodule

// File: rtl/bytedma_pack.sv
module bytedma_pack
  import bytedma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wtype,
  input  logic              cap_byte,
  input  logic              load_word,
  input  logic              byte_step,
  input  logic [BYTE_W-1:0] bm_rdata,
  input  logic [WORD_W-1:0] im_rdata,
  output logic [BYTE_W-1:0] bm_wdata,
  output logic [WORD_W-1:0] im_wdata
);
  logic [WORD_W-1:0] sreg_q, sreg_d;

  always_comb begin
    sreg_d = sreg_q;
    if (load_word)
      sreg_d = wtype ? {im_rdata[15:0], 8'h00} : im_rdata;
    else if (cap_byte)
      sreg_d = {sreg_q[WORD_W-BYTE_W-1:0], bm_rdata};
    else if (byte_step)
      sreg_d = {sreg_q[WORD_W-BYTE_W-1:0], 8'h00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  assign bm_wdata = sreg_q[WORD_W-1:WORD_W-BYTE_W];
  assign im_wdata = wtype ? {8'h00, sreg_q[15:0]} : sreg_q;
endmodule

// File: rtl/bytedma_engine.sv
module bytedma_engine
  import bytedma_pkg::*;
#(
  parameter int PAGE_W     = 8,
  parameter int IA_W       = 14,
  parameter int EA_W       = 14,
  parameter int WS_W       = 3,
  parameter int CNT_W      = 14,
  parameter int CFG_W      = 16,
  parameter int BOOT_WORDS = 32,
  parameter int BOOT_WAIT  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   boot_en,
  input  logic                   cfg_we,
  input  logic [2:0]             cfg_sel,
  input  logic [CFG_W-1:0]       cfg_wdata,
  output logic                   busy,
  output logic                   bm_req,
  output logic                   bm_we,
  output logic [PAGE_W+EA_W-1:0] bm_addr,
  output logic [7:0]             bm_wdata,
  input  logic [7:0]             bm_rdata,
  input  logic                   cpu_ext_req,
  output logic                   im_we,
  output logic                   im_re,
  output logic                   im_dm,
  output logic [IA_W-1:0]        im_addr,
  output logic [23:0]            im_wdata,
  input  logic [23:0]            im_rdata,
  output logic                   proc_hold,
  output logic                   ctx_restart
);
  logic [1:0]        rst_q;
  logic              rst_sync;
  mode_t             mode;
  logic [PAGE_W-1:0] page;
  logic [EA_W-1:0]   eaddr;
  logic [WS_W-1:0]   wait_n;
  logic              last_word, cap_byte, load_word, byte_step, word_step;
  logic              restart_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync = rst_q[1];

  bytedma_regs #(
    .PAGE_W(PAGE_W), .IA_W(IA_W), .EA_W(EA_W), .WS_W(WS_W), .CNT_W(CNT_W),
    .CFG_W(CFG_W), .BOOT_WORDS(BOOT_WORDS), .BOOT_WAIT(BOOT_WAIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync), .boot_en(boot_en),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .byte_step(byte_step), .word_step(word_step),
    .mode(mode), .page(page), .iaddr(im_addr), .eaddr(eaddr),
    .wait_n(wait_n), .busy(busy), .last_word(last_word)
  );

  bytedma_seq #(.WS_W(WS_W)) u_seq (
    .clk(clk), .rst_n(rst_sync), .busy(busy), .last_word(last_word),
    .mode(mode), .wait_n(wait_n), .cpu_ext_req(cpu_ext_req),
    .bm_req(bm_req), .im_we(im_we), .im_re(im_re),
    .cap_byte(cap_byte), .load_word(load_word),
    .byte_step(byte_step), .word_step(word_step)
  );

  bytedma_pack u_pack (
    .clk(clk), .rst_n(rst_sync), .wtype(mode.wtype),
    .cap_byte(cap_byte), .load_word(load_word), .byte_step(byte_step),
    .bm_rdata(bm_rdata), .im_rdata(im_rdata),
    .bm_wdata(bm_wdata), .im_wdata(im_wdata)
  );

  assign bm_we     = bm_req & mode.dir;
  assign bm_addr   = {page, eaddr};
  assign im_dm     = mode.wtype;
  assign proc_hold = busy & mode.ctx;
  assign restart_d = word_step & last_word & mode.ctx;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) ctx_restart <= 1'b0;
    else           ctx_restart <= restart_d;
  end
endmodule

// File: rtl/bytedma_engine_chk.sv
module bytedma_engine_chk #(
  parameter int BA_W = 22
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            bm_req,
  input logic            bm_we,
  input logic [BA_W-1:0] bm_addr,
  input logic            cpu_ext_req,
  input logic            im_we,
  input logic            im_re,
  input logic            proc_hold,
  input logic            ctx_restart
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bm_req && !im_we && !im_re));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && $past(bm_req)) |-> ($stable(bm_addr) && $stable(bm_we)));

  p_single_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    im_we |=> !im_we);

  p_read_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    im_re |-> (!bm_req && !im_we));

  p_yield_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bm_req) |-> !$past(cpu_ext_req));

  p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    proc_hold |-> busy);

  p_restart_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_restart |-> (!busy && $past(busy)));
endmodule

bind bytedma_engine bytedma_engine_chk #(.BA_W(PAGE_W + EA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bm_req(bm_req), .bm_we(bm_we),
  .bm_addr(bm_addr), .cpu_ext_req(cpu_ext_req), .im_we(im_we), .im_re(im_re),
  .proc_hold(proc_hold), .ctx_restart(ctx_restart)
);

// File: tb/bytedma_engine_tb.sv
module bytedma_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        busy, bm_req, bm_we, im_we, im_re, im_dm, proc_hold, ctx_restart;
  logic [21:0] bm_addr;
  logic [7:0]  bm_wdata, bm_rdata;
  logic        cpu_ext_req = 1'b0;
  logic [13:0] im_addr;
  logic [23:0] im_wdata, im_rdata;

  always #10 clk = ~clk;

  bytedma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .busy(busy), .bm_req(bm_req),
    .bm_we(bm_we), .bm_addr(bm_addr), .bm_wdata(bm_wdata), .bm_rdata(bm_rdata),
    .cpu_ext_req(cpu_ext_req), .im_we(im_we), .im_re(im_re), .im_dm(im_dm),
    .im_addr(im_addr), .im_wdata(im_wdata), .im_rdata(im_rdata),
    .proc_hold(proc_hold), .ctx_restart(ctx_restart)
  );

  logic [7:0]  bmem [256];
  logic [23:0] imem [64];

  function automatic logic [7:0] ib(input int a);
    return 8'(a * 37 + 11);
  endfunction
  function automatic logic [23:0] iw(input int a);
    return 24'(a * 24'h0A0B0D + 24'h123456);
  endfunction

  assign bm_rdata = bmem[bm_addr[7:0]];
  always @(posedge clk) begin
    if (bm_req && bm_we) bmem[bm_addr[7:0]] <= bm_wdata;
    if (im_we) imem[im_addr[5:0]] <= im_wdata;
    if (im_re) im_rdata <= imem[im_addr[5:0]];
  end

  int checks = 0, errors = 0;
  int exp_wait = 0, exp_page = 0, exp_ctx = 0;
  int run_len = 0, accesses = 0, wait_bad = 0, writes = 0, restarts = 0;
  int hold_bad = 0, prio_bad = 0, page_bad = 0, cycles = 0;
  logic prev_bm = 1'b0, prev_cpu = 1'b0;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      report();
    end
    if (bm_req) begin
      run_len++;
      if (bm_addr[21:14] != 8'(exp_page)) page_bad++;
      if (!prev_bm && prev_cpu) prio_bad++;
    end else if (prev_bm) begin
      accesses++;
      if (run_len != exp_wait + 1) wait_bad++;
      run_len = 0;
    end
    if (im_we) writes++;
    if (ctx_restart) restarts++;
    if (busy && (exp_ctx != 0) && !proc_hold) hold_bad++;
    if (proc_hold && (exp_ctx == 0)) hold_bad++;
    prev_bm  = bm_req;
    prev_cpu = cpu_ext_req;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    accesses = 0; wait_bad = 0; writes = 0; restarts = 0;
    hold_bad = 0; prio_bad = 0; page_bad = 0; run_len = 0;
  endtask

  task automatic init_mem();
    for (int i = 0; i < 256; i++) bmem[i] = ib(i);
    for (int i = 0; i < 64; i++) imem[i] = iw(i);
  endtask

  task automatic wr(input int sel, input int data);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 16'(data);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset(input bit boot);
    rst_n = 1'b0; boot_en = boot;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic check_words(input int dir, input int wt, input int cnt,
                             input int ia, input int ea, input string tag);
    int nb = wt ? 2 : 3;
    for (int i = 0; i < cnt; i++) begin
      int b = ea + i * nb;
      if (dir == 0) begin
        logic [23:0] e = wt ? {8'h00, ib(b), ib(b+1)} : {ib(b), ib(b+1), ib(b+2)};
        chk(imem[ia+i] == e, tag, imem[ia+i], e);
      end else begin
        logic [23:0] w = iw(ia + i);
        for (int k = 0; k < nb; k++) begin
          logic [7:0] e = wt ? (k == 0 ? w[15:8] : w[7:0]) : 8'(w >> (16 - 8*k));
          chk(bmem[b+k] == e, {tag, " R5 byte"}, bmem[b+k], e);
        end
      end
    end
    if (dir == 0) chk(imem[ia+cnt] == iw(ia+cnt), "R4 past end untouched", imem[ia+cnt], iw(ia+cnt));
    else chk(bmem[ea+cnt*nb] == ib(ea+cnt*nb), "R5 past end untouched",
             bmem[ea+cnt*nb], ib(ea+cnt*nb));
  endtask

  task automatic run(input int dir, input int wt, input int ws, input int cnt,
                     input int ctx, input int pg, input int ia, input int ea);
    init_mem(); clr();
    exp_wait = ws; exp_page = pg; exp_ctx = ctx;
    wr(0, (pg << 3) | (ctx << 2) | (wt << 1) | dir);
    wr(1, ia); wr(2, ea); wr(3, ws); wr(4, cnt);
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    wait_idle();
    check_words(dir, wt, cnt, ia, ea, "R3 R4 data");
    chk(accesses == cnt * (wt ? 2 : 3), "R3 byte access count", accesses, cnt * (wt ? 2 : 3));
    chk(wait_bad == 0, "R2 wait length", wait_bad, 0);
    chk(page_bad == 0, "R2 page", page_bad, 0);
    chk(writes == (dir ? 0 : cnt), "R4 R5 word writes", writes, dir ? 0 : cnt);
    chk(restarts == ctx, "R7 restart pulses", restarts, ctx);
    chk(hold_bad == 0, "R7 hold", hold_bad, 0);
  endtask

  initial begin
    int wsv[3] = '{0, 2, 5};
    init_mem(); clr();
    exp_wait = 3; exp_page = 0; exp_ctx = 1;
    do_reset(1'b1);
    @(negedge clk);
    chk(busy == 1'b1, "R8 boot busy", busy, 1);
    chk(proc_hold == 1'b1, "R8 boot hold", proc_hold, 1);
    wait_idle();
    check_words(0, 0, 32, 0, 0, "R8 boot words");
    chk(accesses == 96, "R8 boot accesses", accesses, 96);
    chk(wait_bad == 0, "R8 boot wait", wait_bad, 0);
    chk(restarts == 1, "R8 boot restart", restarts, 1);
    chk(hold_bad == 0, "R8 boot hold span", hold_bad, 0);

    exp_ctx = 0;
    do_reset(1'b0);
    @(negedge clk);
    chk(busy == 1'b0, "R9 idle after reset", busy, 0);
    chk(proc_hold == 1'b0, "R9 no hold", proc_hold, 0);
    repeat (3) @(negedge clk);

    clr();
    wr(4, 0);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1 zero count stays idle", busy, 0);
    chk(accesses == 0 && !bm_req, "R1 zero count no access", accesses, 0);

    for (int d = 0; d < 2; d++)
      for (int t = 0; t < 2; t++)
        for (int w = 0; w < 3; w++)
          for (int c = 0; c < 2; c++)
            run(d, t, wsv[w], c ? 4 : 1, (d + w + c) % 2, 8'hA5 ^ w,
                5 + d * 20, 30 + t * 60);

    init_mem(); clr();
    exp_wait = 1; exp_page = 3; exp_ctx = 0;
    wr(0, 3 << 3); wr(1, 2); wr(2, 10); wr(3, 1); wr(4, 3);
    repeat (4) @(posedge clk);
    wr(4, 9); wr(2, 200); wr(0, 4);
    wait_idle();
    chk(writes == 3, "R10 count write ignored", writes, 3);
    check_words(0, 0, 3, 2, 10, "R10 address write ignored");
    chk(hold_bad == 0, "R10 ctrl write ignored", hold_bad, 0);

    init_mem(); clr();
    exp_wait = 0; exp_page = 0; exp_ctx = 1;
    wr(0, 4); wr(1, 40); wr(2, 150); wr(3, 0); wr(4, 4);
    while (busy) begin
      @(posedge clk); #1 cpu_ext_req = 1'b1;
      repeat (4) @(posedge clk);
      #1 cpu_ext_req = 1'b0;
      repeat (2) @(posedge clk);
    end
    #1 cpu_ext_req = 1'b0;
    wait_idle();
    chk(prio_bad == 0, "R6 no access after cpu request", prio_bad, 0);
    chk(accesses == 12, "R6 all bytes done", accesses, 12);
    check_words(0, 0, 4, 40, 150, "R6 data");
    chk(restarts == 1, "R7 restart with priority", restarts, 1);

    report();
  end
endmodule